// File: doc/BRIEF.md
# Event Counter Bank with Interval Timers

This block holds a bank of event counters for measuring hardware activity. Each counter picks one line from a wide event bus. It counts either rising edges of that line or the clock cycles during which the line is high. A counter may instead be linked to the counter just below it, so that the pair acts as one counter of twice the width. The lowest counters also serve as interval timers. Each of these compares its count against a programmable match value and, on a hit, can latch a flag that drives an interrupt, pulse a debug-trigger line, and wrap back to zero.

Software reaches the bank through a word-addressed register port, with a read latency of one cycle. A module-wide enable gates all counting. Per-counter bits let a counter keep running while the processor is halted for debug or sitting idle. Two group registers enable or clear every counter in a single write. A wrap flag on each counter records that it passed its maximum value, and the flag clears when software reads that counter's value. All counts are `CNT_W` bits wide, with a default of 32.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset every count, control word, match value and match flag is zero, the module enable is off, and irq and dbgTrig are low.
- R2: With control bit 8 (enable) set and bit 11 clear, a counter adds one on each rising edge of event line `sel`, where `sel` is control bits 4:0.
- R3: With control bit 11 set, a counter adds one on every clock cycle in which its selected event line is high.
- R4: With control bit 10 set on counter m (m ≥ 1), counter m ignores its event and adds one only in the cycle where counter m-1 wraps from all ones to zero.
- R5: A counter's wrap flag reads as control-word bit 24 and sets when the counter wraps. A read of that counter's value at address 24+m clears it.
- R6: Bit 0 at address 0 is the module enable. While it is 0, no count changes except through a reset.
- R7: While cpuHalt is high, a counter holds unless control bit 12 is set. While cpuIdle is high, a counter holds unless control bit 13 is set.
- R8: Address 1 reads and writes all per-counter enable bits at once, with bit m for counter m. Writing 1 to bit m at address 2 zeroes counter m, and address 2 reads as zero.
- R9: Writing a control word with bit 9 set zeroes the count on the next edge. Bit 9 always reads back as 0.
- R10: Timer t sets match flag t (address 3, bit t) when an increment brings its count to the match value at address 8+t. Writing 1 to the flag bit clears it. irq is the OR of the flags whose control bit 14 is set.
- R11: A timer match with control bit 15 set drives dbgTrig high for exactly one cycle, starting at the edge that makes the matching increment.
- R12: A timer match with control bit 16 set loads zero instead of the match value. Without bit 16 the count carries on past the match.
- R13: rdData presents the register addressed during an rdEn cycle from the following cycle on. Match values are CNT_W bits wide, control words are at 16+m and counts are at 24+m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, registered |
| evtIn | input | NUM_EVT | Event bus |
| cpuHalt | input | 1 | Processor is in debug halt |
| cpuIdle | input | 1 | Processor is idle |
| irq | output | 1 | Interrupt from enabled timer match flags |
| dbgTrig | output | 1 | One-cycle debug trigger on timer match |

## Verification
The assertions check several properties on every cycle. A count stays frozen while the module enable is off, and while the processor is halted for a counter without its free bit. A clear strobe always leaves zero. A wrap flag can only rise after its counter held all ones. A flag clear takes effect, and irq and dbgTrig only rise after a timer match (or, for irq, a register write). The bench scenarios show what the assertions cannot: the exact counts under edge and level counting on a shared line, the counts across a linked pair, the wrap flag clearing on a read, the restart-to-zero versus run-through behaviour at a match, and the register readback encodings.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int SEL_W = 5;

  // control word bit positions
  localparam int CW_SEL     = 0;
  localparam int CW_EN      = 8;
  localparam int CW_RST     = 9;
  localparam int CW_CHAIN   = 10;
  localparam int CW_DUR     = 11;
  localparam int CW_FREE    = 12;
  localparam int CW_IDLE    = 13;
  localparam int CW_IRQ     = 14;
  localparam int CW_DBG     = 15;
  localparam int CW_RESTART = 16;
  localparam int CW_OVF     = 24;

  // word addresses
  localparam int A_GLB   = 0;
  localparam int A_GEN   = 1;
  localparam int A_GRST  = 2;
  localparam int A_FLAG  = 3;
  localparam int A_MATCH = 8;
  localparam int A_CTL   = 16;
  localparam int A_CNT   = 24;

  typedef struct packed {
    logic             restart;
    logic             dbgEn;
    logic             irqEn;
    logic             idleOk;
    logic             freeRun;
    logic             dur;
    logic             chain;
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctrCfg_t;

  typedef struct packed {
    logic clr;
    logic ovClr;
  } ctrStb_t;
endpackage

// File: rtl/evt_ctr_ctrl.sv
module evt_ctr_ctrl
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic                             rdEn,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wrData,
  output logic [DATA_W-1:0]                rdData,
  input  logic [NUM_CTR-1:0][CNT_W-1:0]    cntVal,
  input  logic [NUM_CTR-1:0]               ovFlag,
  input  logic [NUM_TMR-1:0]               hit,
  output ctrCfg_t [NUM_CTR-1:0]            cfg,
  output ctrStb_t [NUM_CTR-1:0]            stb,
  output logic                             glbEn,
  output logic [NUM_TMR-1:0][CNT_W-1:0]    matchVal,
  output logic [NUM_TMR-1:0]               matchFlag,
  output logic                             irq
);
  function automatic logic [DATA_W-1:0] packCw(input ctrCfg_t c, input logic ov);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CW_SEL +: SEL_W] = c.sel;
    w[CW_EN]      = c.en;
    w[CW_CHAIN]   = c.chain;
    w[CW_DUR]     = c.dur;
    w[CW_FREE]    = c.freeRun;
    w[CW_IDLE]    = c.idleOk;
    w[CW_IRQ]     = c.irqEn;
    w[CW_DBG]     = c.dbgEn;
    w[CW_RESTART] = c.restart;
    w[CW_OVF]     = ov;
    return w;
  endfunction

  function automatic ctrCfg_t unpackCw(input logic [DATA_W-1:0] w);
    ctrCfg_t c;
    c.sel     = w[CW_SEL +: SEL_W];
    c.en      = w[CW_EN];
    c.chain   = w[CW_CHAIN];
    c.dur     = w[CW_DUR];
    c.freeRun = w[CW_FREE];
    c.idleOk  = w[CW_IDLE];
    c.irqEn   = w[CW_IRQ];
    c.dbgEn   = w[CW_DBG];
    c.restart = w[CW_RESTART];
    return c;
  endfunction

  logic                  flagClrWr;
  logic [DATA_W-1:0]     rdMux;
  logic [NUM_TMR-1:0]    irqMask;

  assign flagClrWr = wrEn && (addr == ADDR_W'(A_FLAG));

  // strobes towards the datapath
  always_comb begin
    for (int m = 0; m < NUM_CTR; m++) begin
      stb[m].clr   = wrEn && (((addr == ADDR_W'(A_CTL + m)) && wrData[CW_RST]) ||
                              ((addr == ADDR_W'(A_GRST)) && wrData[m]));
      stb[m].ovClr = rdEn && (addr == ADDR_W'(A_CNT + m));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      glbEn     <= 1'b0;
      cfg       <= '0;
      matchVal  <= '0;
      matchFlag <= '0;
    end else begin
      if (wrEn && addr == ADDR_W'(A_GLB)) glbEn <= wrData[0];
      for (int m = 0; m < NUM_CTR; m++) begin
        if (wrEn && addr == ADDR_W'(A_CTL + m)) cfg[m] <= unpackCw(wrData);
        else if (wrEn && addr == ADDR_W'(A_GEN)) cfg[m].en <= wrData[m];
      end
      for (int t = 0; t < NUM_TMR; t++) begin
        if (wrEn && addr == ADDR_W'(A_MATCH + t)) matchVal[t] <= wrData[CNT_W-1:0];
        matchFlag[t] <= hit[t] | (matchFlag[t] & ~(flagClrWr & wrData[t]));
      end
    end
  end

  always_comb begin
    for (int t = 0; t < NUM_TMR; t++) irqMask[t] = matchFlag[t] & cfg[t].irqEn;
  end
  assign irq = |irqMask;

  // read multiplexer
  always_comb begin
    rdMux = '0;
    if (addr == ADDR_W'(A_GLB)) rdMux[0] = glbEn;
    if (addr == ADDR_W'(A_GEN))
      for (int m = 0; m < NUM_CTR; m++) rdMux[m] = cfg[m].en;
    if (addr == ADDR_W'(A_FLAG)) rdMux[NUM_TMR-1:0] = matchFlag;
    for (int t = 0; t < NUM_TMR; t++)
      if (addr == ADDR_W'(A_MATCH + t)) rdMux[CNT_W-1:0] = matchVal[t];
    for (int m = 0; m < NUM_CTR; m++) begin
      if (addr == ADDR_W'(A_CTL + m)) rdMux = packCw(cfg[m], ovFlag[m]);
      if (addr == ADDR_W'(A_CNT + m)) rdMux[CNT_W-1:0] = cntVal[m];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end
endmodule

// File: rtl/evt_ctr_dp.sv
module evt_ctr_dp
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int NUM_TMR = 2,
  parameter int NUM_EVT = 32,
  parameter int CNT_W   = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_EVT-1:0]            evtIn,
  input  logic                          cpuHalt,
  input  logic                          cpuIdle,
  input  logic                          glbEn,
  input  ctrCfg_t [NUM_CTR-1:0]         cfg,
  input  ctrStb_t [NUM_CTR-1:0]         stb,
  input  logic [NUM_TMR-1:0][CNT_W-1:0] matchVal,
  output logic [NUM_CTR-1:0][CNT_W-1:0] cntVal,
  output logic [NUM_CTR-1:0]            ovFlag,
  output logic [NUM_TMR-1:0]            hit,
  output logic                          dbgTrig
);
  logic [NUM_EVT-1:0] evtPrev;
  logic [NUM_CTR-1:0] inc;
  logic [NUM_CTR-1:0] wrap;
  logic [NUM_CTR-1:0] reload;
  logic [NUM_TMR-1:0] dbgHit;

  // increment decision with carry ripple from lower neighbour
  always_comb begin
    logic lowWrap, evtNow, evtOld, src, active;
    lowWrap = 1'b0;
    for (int m = 0; m < NUM_CTR; m++) begin
      evtNow = 1'b0;
      evtOld = 1'b0;
      for (int e = 0; e < NUM_EVT; e++) begin
        if (cfg[m].sel == SEL_W'(e)) begin
          evtNow = evtIn[e];
          evtOld = evtPrev[e];
        end
      end
      active = glbEn & cfg[m].en & (~cpuHalt | cfg[m].freeRun) &
               (~cpuIdle | cfg[m].idleOk);
      src = cfg[m].dur ? evtNow : (evtNow & ~evtOld);
      if (m != 0 && cfg[m].chain) src = lowWrap;
      inc[m]  = active & src & ~stb[m].clr;
      wrap[m] = inc[m] & (&cntVal[m]);
      lowWrap = wrap[m];
    end
  end

  always_comb begin
    reload = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      hit[t]    = inc[t] && ((cntVal[t] + CNT_W'(1)) == matchVal[t]);
      reload[t] = hit[t] & cfg[t].restart;
      dbgHit[t] = hit[t] & cfg[t].dbgEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal  <= '0;
      ovFlag  <= '0;
      evtPrev <= '0;
      dbgTrig <= 1'b0;
    end else begin
      evtPrev <= evtIn;
      dbgTrig <= |dbgHit;
      for (int m = 0; m < NUM_CTR; m++) begin
        if (stb[m].clr || reload[m]) cntVal[m] <= '0;
        else if (inc[m])             cntVal[m] <= cntVal[m] + CNT_W'(1);
        ovFlag[m] <= wrap[m] | (ovFlag[m] & ~stb[m].ovClr);
      end
    end
  end
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int NUM_TMR = 2,
  parameter int NUM_EVT = 32,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               cpuHalt,
  input  logic               cpuIdle,
  output logic               irq,
  output logic               dbgTrig
);
  ctrCfg_t [NUM_CTR-1:0]         cfg;
  ctrStb_t [NUM_CTR-1:0]         stb;
  logic                          glbEn;
  logic [NUM_TMR-1:0][CNT_W-1:0] matchVal;
  logic [NUM_TMR-1:0]            matchFlag;
  logic [NUM_CTR-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CTR-1:0]            ovFlag;
  logic [NUM_TMR-1:0]            hit;

  evt_ctr_ctrl #(
    .NUM_CTR(NUM_CTR), .NUM_TMR(NUM_TMR), .CNT_W(CNT_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cntVal(cntVal), .ovFlag(ovFlag),
    .hit(hit), .cfg(cfg), .stb(stb), .glbEn(glbEn), .matchVal(matchVal),
    .matchFlag(matchFlag), .irq(irq)
  );

  evt_ctr_dp #(
    .NUM_CTR(NUM_CTR), .NUM_TMR(NUM_TMR), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .cpuHalt(cpuHalt),
    .cpuIdle(cpuIdle), .glbEn(glbEn), .cfg(cfg), .stb(stb),
    .matchVal(matchVal), .cntVal(cntVal), .ovFlag(ovFlag), .hit(hit),
    .dbgTrig(dbgTrig)
  );
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic [ADDR_W-1:0]             addr,
  input logic [DATA_W-1:0]             wrData,
  input logic                          cpuHalt,
  input logic                          glbEn,
  input ctrCfg_t [NUM_CTR-1:0]         cfg,
  input ctrStb_t [NUM_CTR-1:0]         stb,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cntVal,
  input logic [NUM_CTR-1:0]            ovFlag,
  input logic [NUM_TMR-1:0]            hit,
  input logic [NUM_TMR-1:0]            matchFlag,
  input logic                          irq,
  input logic                          dbgTrig
);
  for (genvar m = 0; m < NUM_CTR; m++) begin : g_ctr
    a_r6_gate_off: assert property (@(posedge clk) disable iff (!rstN)
      (!glbEn && !stb[m].clr) |=> $stable(cntVal[m]));
    a_r9_clr_zero: assert property (@(posedge clk) disable iff (!rstN)
      stb[m].clr |=> (cntVal[m] == '0));
    a_r5_ov_after_full: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovFlag[m]) |-> (&$past(cntVal[m])));
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
      (cpuHalt && !cfg[m].freeRun && !stb[m].clr) |=> $stable(cntVal[m]));
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(A_FLAG) && wrData[t] && !hit[t]) |=> !matchFlag[t]);
  end

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(|hit) || $past(wrEn)));
  a_r11_dbg_source: assert property (@(posedge clk) disable iff (!rstN)
    dbgTrig |-> $past(|hit));
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(
  .NUM_CTR(NUM_CTR), .NUM_TMR(NUM_TMR), .CNT_W(CNT_W),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .cpuHalt(cpuHalt), .glbEn(glbEn), .cfg(cfg), .stb(stb), .cntVal(cntVal),
  .ovFlag(ovFlag), .hit(hit), .matchFlag(matchFlag), .irq(irq),
  .dbgTrig(dbgTrig)
);

// File: tb/sim_evt_ctr_bank.sv
module sim_evt_ctr_bank;
  localparam int NUM_CTR = 8;
  localparam int NUM_TMR = 2;
  localparam int NUM_EVT = 32;
  localparam int CNT_W   = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;

  logic               clk = 1'b0;
  logic               rstN;
  logic               wrEn = 1'b0;
  logic               rdEn = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [DATA_W-1:0]  wrData = '0;
  logic [DATA_W-1:0]  rdData;
  logic [NUM_EVT-1:0] evtIn = '0;
  logic               cpuHalt = 1'b0;
  logic               cpuIdle = 1'b0;
  logic               irq;
  logic               dbgTrig;

  int nRun  = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  evt_ctr_bank #(
    .NUM_CTR(NUM_CTR), .NUM_TMR(NUM_TMR), .NUM_EVT(NUM_EVT),
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .cpuHalt(cpuHalt),
    .cpuIdle(cpuIdle), .irq(irq), .dbgTrig(dbgTrig)
  );

  typedef struct packed {
    logic              isWr;
    logic [ADDR_W-1:0] a;
    logic [31:0]       d;
    logic [31:0]       exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 5'd8,  32'h0000_01C3, 32'h0},           // R13 match truncated to CNT_W
    '{1'b0, 5'd8,  32'h0,         32'h0000_00C3},
    '{1'b1, 5'd21, 32'h0000_0F09, 32'h0},           // R9 reset bit set in write
    '{1'b0, 5'd21, 32'h0,         32'h0000_0D09},   // R9 reads back as 0
    '{1'b1, 5'd1,  32'h0000_00A5, 32'h0},           // R8 group enable
    '{1'b0, 5'd1,  32'h0,         32'h0000_00A5},
    '{1'b0, 5'd21, 32'h0,         32'h0000_0D09},
    '{1'b1, 5'd1,  32'h0000_0000, 32'h0},
    '{1'b0, 5'd21, 32'h0,         32'h0000_0C09},   // R8 enable cleared by group
    '{1'b0, 5'd0,  32'h0,         32'h0},           // R6 module enable off
    '{1'b1, 5'd0,  32'h0000_0001, 32'h0},
    '{1'b0, 5'd0,  32'h0,         32'h0000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic hold(input int idx, input int n);
    @(negedge clk);
    evtIn[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evtIn[idx] = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 dbgTrig", {31'b0, dbgTrig}, 32'h0);
    rd(5'd24, v); chk("R1 count0", v, 32'h0);
    rd(5'd16, v); chk("R1 ctl0", v, 32'h0);
    rd(5'd3, v);  chk("R1 flags", v, 32'h0);

    // table walk: register readback, group enable, module enable (R13 R9 R8 R6)
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWr) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        chk("R13 table", v, VEC[i].exp);
      end
    end

    // R2 / R3 occurrence and duration on the same line 3
    wr(5'd16, 32'h0000_0103);
    wr(5'd17, 32'h0000_0903);
    hold(3, 3);
    hold(3, 2);
    rd(5'd24, v); chk("R2 edges", v, 32'd2);
    rd(5'd25, v); chk("R3 cycles", v, 32'd5);

    // R6 module enable off freezes counts
    wr(5'd0, 32'h0);
    hold(3, 4);
    rd(5'd24, v); chk("R6 frozen c0", v, 32'd2);
    rd(5'd25, v); chk("R6 frozen c1", v, 32'd5);
    wr(5'd0, 32'h1);

    // R8 group reset
    wr(5'd2, 32'h0000_0003);
    rd(5'd24, v); chk("R8 grp reset c0", v, 32'd0);
    rd(5'd25, v); chk("R8 grp reset c1", v, 32'd0);
    rd(5'd2, v);  chk("R8 grp reset reads 0", v, 32'd0);

    // R7 halt and idle gating: c0 idle-ok, c1 free
    wr(5'd16, 32'h0000_2907);
    wr(5'd17, 32'h0000_1907);
    cpuHalt = 1'b1;
    hold(7, 3);
    cpuHalt = 1'b0;
    cpuIdle = 1'b1;
    hold(7, 2);
    cpuIdle = 1'b0;
    rd(5'd24, v); chk("R7 idle-ok counter", v, 32'd2);
    rd(5'd25, v); chk("R7 free counter", v, 32'd3);

    // R9 per-counter reset bit
    wr(5'd16, 32'h0000_2B07);
    rd(5'd24, v); chk("R9 count cleared", v, 32'd0);
    rd(5'd16, v); chk("R9 bit reads 0", v, 32'h0000_2907);

    // R4 / R5 chained pair and wrap flag
    wr(5'd18, 32'h0000_0905);
    wr(5'd19, 32'h0000_0500);
    hold(5, 259);
    rd(5'd18, v); chk("R5 wrap flag set", v, 32'h0100_0905);
    rd(5'd26, v); chk("R4 low count", v, 32'd3);
    rd(5'd18, v); chk("R5 wrap flag cleared by read", v, 32'h0000_0905);
    rd(5'd27, v); chk("R4 high count", v, 32'd1);
    rd(5'd19, v); chk("R5 high no wrap", v, 32'h0000_0500);

    // R10 R11 R12 timers
    wr(5'd2, 32'h0000_00FF);
    wr(5'd8, 32'd4);
    wr(5'd9, 32'd2);
    wr(5'd16, 32'h0001_C906);
    wr(5'd17, 32'h0000_0906);
    @(negedge clk);
    evtIn[6] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 no early trigger", {31'b0, dbgTrig}, 32'h0);
    chk("R10 no early irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    evtIn[6] = 1'b0;
    chk("R11 trigger on match", {31'b0, dbgTrig}, 32'h1);
    chk("R10 irq on match", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R11 one cycle", {31'b0, dbgTrig}, 32'h0);
    chk("R10 irq held", {31'b0, irq}, 32'h1);
    rd(5'd24, v); chk("R12 restart to zero", v, 32'd0);
    rd(5'd25, v); chk("R12 no restart runs on", v, 32'd4);
    rd(5'd3, v);  chk("R10 both flags", v, 32'h3);
    wr(5'd3, 32'h1);
    chk("R10 irq cleared, masked flag", {31'b0, irq}, 32'h0);
    rd(5'd3, v);  chk("R10 flag1 remains", v, 32'h2);

    finish_run();
  end
endmodule